// File: doc/BRIEF.md
# Slot Interrupt Router and Trigger

This block takes interrupt reports from the PCI slots of a board and funnels them onto one processor interrupt line. Each report names a slot number, an interrupt pin of that slot (INTA to INTD, coded 0 to 3) and the pin's new level. A fixed board routing table turns the slot and pin into an internal line number. Onboard devices get dedicated lines, and the add-in slots share a rotated group of lines.

Line numbers start at a base of 32. The internal index of a line is its number minus 32, and it selects one bit of the edge word and one bit of the polarity word. A line whose edge bit is set produces a one-cycle pulse on the processor interrupt. A line whose edge bit is clear sets the held output to its polarity bit. A report acts only if it changes the level last recorded for that internal index.

Reports are sampled on a rising clock edge while `evt_valid` is high. The output is registered, so a report's effect is visible from the cycle after the edge that samples it.

Top module: `irq_slot_router`

## Requirements
- R1: While reset is asserted and after it is released, `cpu_irq` is 0 until a report acts on it.
- R2: Slot 5 routes pin p to line 32 + (p mod 4), which is internal index p.
- R3: Slot 6 routes every pin to internal index 4, and slot 7 routes every pin to internal index 5.
- R4: Slots 8 to 12 route pin p to internal index (slot - 8 + p) + 6. Slot 12 with pin 3 therefore reaches index 13.
- R5: Any other slot passes the pin number through as the line number. Such a line has no internal index in the range 0 to 31, so its reports leave `cpu_irq` unchanged.
- R6: When a report changes an index whose edge bit is 1, `cpu_irq` is high for exactly one cycle: the cycle after the sampling edge. It is low again in the following cycle unless something else holds it high.
- R7: When a report changes an index whose edge bit is 0, the held output takes that index's polarity bit from the next cycle on. Polarity 1 raises it and polarity 0 lowers it, whatever level the report carries.
- R8: A report counts as a change only if its level differs from the level last recorded for the same internal index. All recorded levels are 0 after reset. A report that repeats the recorded level has no effect.
- R9: `cpu_irq` is the OR of the held level and the edge pulse. A pulse leaves the held level as it was.
- R10: In a cycle with no report, the held level does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; reports are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | A pin report is present this cycle |
| evt_slot | input | 5 | Slot number of the reporting device |
| evt_pin | input | 2 | Interrupt pin of the slot, 0 to 3 for INTA to INTD |
| evt_level | input | 1 | New level of the reported pin |
| edge_cfg | input | 32 | Per internal index: 1 selects pulse mode, 0 selects level mode |
| pol_cfg | input | 32 | Per internal index: value the held output takes in level mode |
| cpu_irq | output | 1 | Processor interrupt line |

## Verification
Some properties are checked on every cycle by the assertions. These are the routing table for the onboard slots, the rejection of slots outside the table, the rule that a pulse only follows a report, and the rule that the output holds when no report arrives. The bench's scenarios are needed for the rest. Change detection depends on the history of levels recorded per index, and the level-mode result depends on the polarity word rather than on the reported level. The bench also shows that a pulse lasts exactly one cycle and leaves the held level in place, using a reference model compared on every clock.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
   localparam int PIN_W = 2;   // INTA..INTD

   typedef enum logic {
      TRIG_LEVEL = 1'b0,
      TRIG_EDGE  = 1'b1
   } trig_mode_e;
endpackage

// File: rtl/slot_line_map.sv
module slot_line_map
   import irq_route_pkg::*;
#(
   parameter int SLOT_W      = 5,
   parameter int LINE_W      = 8,
   parameter int LINE_BASE   = 32,
   parameter int SB_SLOT     = 5,
   parameter int VGA_SLOT    = 6,
   parameter int NIC_SLOT    = 7,
   parameter int VGA_LINE    = 4,
   parameter int NIC_LINE    = 5,
   parameter int ADDIN_FIRST = 8,
   parameter int ADDIN_LAST  = 12,
   parameter int ADDIN_OFS   = 6
) (
   input  logic [SLOT_W-1:0] slot,
   input  logic [PIN_W-1:0]  pin,
   output logic [LINE_W-1:0] line
);
   localparam logic [LINE_W-1:0] BASE_L  = LINE_W'(LINE_BASE);
   localparam logic [LINE_W-1:0] VGA_L   = LINE_W'(LINE_BASE + VGA_LINE);
   localparam logic [LINE_W-1:0] NIC_L   = LINE_W'(LINE_BASE + NIC_LINE);
   localparam logic [LINE_W-1:0] ADD_L   = LINE_W'(LINE_BASE + ADDIN_OFS);
   localparam logic [LINE_W-1:0] FIRST_L = LINE_W'(ADDIN_FIRST);

   logic [LINE_W-1:0] slot_l;
   logic [LINE_W-1:0] pin_l;

   assign slot_l = LINE_W'(slot);
   assign pin_l  = LINE_W'(pin);   // two-bit pin is already pin mod 4

   always_comb begin
      if (slot == SLOT_W'(SB_SLOT))
         line = BASE_L + pin_l;
      else if (slot == SLOT_W'(VGA_SLOT))
         line = VGA_L;
      else if (slot == SLOT_W'(NIC_SLOT))
         line = NIC_L;
      else if (slot >= SLOT_W'(ADDIN_FIRST) && slot <= SLOT_W'(ADDIN_LAST))
         line = slot_l - FIRST_L + pin_l + ADD_L;
      else
         line = pin_l;
   end
endmodule

// File: rtl/line_index_decode.sv
module line_index_decode #(
   parameter int LINE_W    = 8,
   parameter int LINE_BASE = 32,
   parameter int NUM_LINES = 32,
   parameter int IDX_W     = 5
) (
   input  logic [LINE_W-1:0] line,
   output logic              hit,
   output logic [IDX_W-1:0]  idx
);
   localparam logic [LINE_W-1:0] LO_L = LINE_W'(LINE_BASE);
   localparam logic [LINE_W-1:0] HI_L = LINE_W'(LINE_BASE + NUM_LINES);

   logic [LINE_W-1:0] offs;

   assign offs = line - LO_L;
   assign hit  = (line >= LO_L) && (line < HI_L);
   assign idx  = offs[IDX_W-1:0];
endmodule

// File: rtl/irq_trigger_core.sv
module irq_trigger_core
   import irq_route_pkg::*;
#(
   parameter int NUM_LINES = 32,
   parameter int IDX_W     = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 act,
   input  logic [IDX_W-1:0]     idx,
   input  logic                 level,
   input  logic [NUM_LINES-1:0] edge_cfg,
   input  logic [NUM_LINES-1:0] pol_cfg,
   output logic                 pulse_o,
   output logic                 level_o
);
   logic [NUM_LINES-1:0] seen;
   logic                 changed;
   trig_mode_e           mode;

   assign changed = act && (seen[idx] != level);
   assign mode    = edge_cfg[idx] ? TRIG_EDGE : TRIG_LEVEL;

   // one recorded level per internal line
   for (genvar i = 0; i < NUM_LINES; i++) begin : g_seen
      logic seen_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            seen_q <= 1'b0;
         else if (changed && idx == IDX_W'(i))
            seen_q <= level;
      end
      assign seen[i] = seen_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pulse_o <= 1'b0;
         level_o <= 1'b0;
      end else begin
         pulse_o <= changed && (mode == TRIG_EDGE);
         if (changed && mode == TRIG_LEVEL)
            level_o <= pol_cfg[idx];
      end
   end
endmodule

// File: rtl/irq_slot_router.sv
module irq_slot_router
   import irq_route_pkg::*;
#(
   parameter int SLOT_W    = 5,
   parameter int LINE_W    = 8,
   parameter int LINE_BASE = 32,
   parameter int NUM_LINES = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 evt_valid,
   input  logic [SLOT_W-1:0]    evt_slot,
   input  logic [PIN_W-1:0]     evt_pin,
   input  logic                 evt_level,
   input  logic [NUM_LINES-1:0] edge_cfg,
   input  logic [NUM_LINES-1:0] pol_cfg,
   output logic                 cpu_irq
);
   localparam int IDX_W = $clog2(NUM_LINES);

   initial begin
      assert (NUM_LINES >= 2 && (1 << IDX_W) == NUM_LINES)
         else $error("NUM_LINES must be a power of two");
      assert (LINE_BASE + NUM_LINES < (1 << LINE_W))
         else $error("LINE_W too narrow for the line range");
      assert (SLOT_W >= 4) else $error("SLOT_W must cover slot 12");
   end

   logic [LINE_W-1:0] route_line;
   logic              route_hit;
   logic [IDX_W-1:0]  route_idx;
   logic              edge_pulse;
   logic              held_level;

   slot_line_map #(
      .SLOT_W(SLOT_W), .LINE_W(LINE_W), .LINE_BASE(LINE_BASE)
   ) u_map (
      .slot(evt_slot), .pin(evt_pin), .line(route_line)
   );

   line_index_decode #(
      .LINE_W(LINE_W), .LINE_BASE(LINE_BASE),
      .NUM_LINES(NUM_LINES), .IDX_W(IDX_W)
   ) u_dec (
      .line(route_line), .hit(route_hit), .idx(route_idx)
   );

   irq_trigger_core #(
      .NUM_LINES(NUM_LINES), .IDX_W(IDX_W)
   ) u_trig (
      .clk(clk), .rst_n(rst_n),
      .act(evt_valid && route_hit), .idx(route_idx), .level(evt_level),
      .edge_cfg(edge_cfg), .pol_cfg(pol_cfg),
      .pulse_o(edge_pulse), .level_o(held_level)
   );

   assign cpu_irq = held_level | edge_pulse;
endmodule

// File: rtl/irq_slot_router_chk.sv
module irq_slot_router_chk #(
   parameter int SLOT_W = 5,
   parameter int IDX_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              evt_valid,
   input logic [SLOT_W-1:0] evt_slot,
   input logic [1:0]        evt_pin,
   input logic              route_hit,
   input logic [IDX_W-1:0]  route_idx,
   input logic              edge_pulse,
   input logic              cpu_irq
);
   logic outside;
   assign outside = (evt_slot < SLOT_W'(5)) || (evt_slot > SLOT_W'(12));

   // R2
   sb_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && evt_slot == SLOT_W'(5)) |-> (route_hit && route_idx == IDX_W'(evt_pin)));

   // R3
   vga_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && evt_slot == SLOT_W'(6)) |-> (route_hit && route_idx == IDX_W'(4)));

   // R3
   nic_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && evt_slot == SLOT_W'(7)) |-> (route_hit && route_idx == IDX_W'(5)));

   // R5
   outside_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && outside) |-> !route_hit);

   // R6
   pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_valid |=> !edge_pulse);

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt_valid && !edge_pulse) |=> $stable(cpu_irq));
endmodule

bind irq_slot_router irq_slot_router_chk #(.SLOT_W(SLOT_W), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_slot(evt_slot),
   .evt_pin(evt_pin), .route_hit(route_hit), .route_idx(route_idx),
   .edge_pulse(edge_pulse), .cpu_irq(cpu_irq)
);

// File: tb/irq_slot_router_tb.sv
`timescale 1ns/100ps
module irq_slot_router_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        evt_valid = 1'b0;
   logic [4:0]  evt_slot = '0;
   logic [1:0]  evt_pin = '0;
   logic        evt_level = 1'b0;
   logic [31:0] edge_cfg = '0;
   logic [31:0] pol_cfg = '0;
   logic        cpu_irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   irq_slot_router u_dut (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_slot(evt_slot),
      .evt_pin(evt_pin), .evt_level(evt_level), .edge_cfg(edge_cfg),
      .pol_cfg(pol_cfg), .cpu_irq(cpu_irq)
   );

   // behavioural reference model
   bit m_last[32];
   bit m_hold = 1'b0;
   bit m_pulse = 1'b0;

   function automatic int ref_line(int s, int p);
      if (s == 5)                return 32 + (p % 4);
      else if (s == 6)           return 36;
      else if (s == 7)           return 37;
      else if (s >= 8 && s <= 12) return (s - 8 + p) + 6 + 32;
      else                       return p;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_last[k]) m_last[k] = 1'b0;
         m_hold = 1'b0;
         m_pulse = 1'b0;
      end else begin
         m_pulse = 1'b0;
         if (evt_valid) begin
            int ix;
            ix = ref_line(int'(evt_slot), int'(evt_pin)) - 32;
            if (ix >= 0 && ix < 32 && m_last[ix] != evt_level) begin
               m_last[ix] = evt_level;
               if (edge_cfg[ix]) m_pulse = 1'b1;
               else              m_hold = pol_cfg[ix];
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (cpu_irq !== (m_hold | m_pulse)) begin
            errors++;
            $display("FAIL model R10 t=%0t actual=%b expected=%b", $time, cpu_irq, m_hold | m_pulse);
         end
      end
   end

   task automatic chk(string tag, logic exp);
      checks++;
      if (cpu_irq !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", tag, cpu_irq, exp);
      end
   endtask

   // drive at a falling edge, sampled at the next rising edge, observe at the falling edge after
   task automatic send(int s, int p, logic lv);
      evt_slot  = 5'(s);
      evt_pin   = 2'(p);
      evt_level = lv;
      evt_valid = 1'b1;
      @(negedge clk);
      evt_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 in reset", 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset", 1'b0);

      pol_cfg = 32'h1 << 2;
      send(5, 2, 1'b1);  chk("R2 slot5 pin2 idx2", 1'b1);
      send(5, 2, 1'b0);  chk("R7 level ignored, polarity kept", 1'b1);
      pol_cfg = 32'h0;
      send(5, 2, 1'b1);  chk("R7 polarity 0 lowers", 1'b0);
      pol_cfg = 32'h1 << 2;
      send(5, 2, 1'b1);  chk("R8 repeated level no effect", 1'b0);

      pol_cfg = 32'h1 << 4;
      send(6, 3, 1'b1);  chk("R3 slot6 idx4", 1'b1);
      send(7, 1, 1'b1);  chk("R3 slot7 idx5", 1'b0);

      pol_cfg = 32'h1 << 11;
      send(10, 3, 1'b1); chk("R4 slot10 pin3 idx11", 1'b1);
      send(9, 0, 1'b1);  chk("R4 slot9 pin0 idx7", 1'b0);
      pol_cfg = 32'h1 << 13;
      send(12, 3, 1'b1); chk("R4 slot12 pin3 idx13", 1'b1);

      pol_cfg = 32'h0;
      send(3, 1, 1'b1);  chk("R5 slot3 ignored", 1'b1);
      send(0, 3, 1'b1);  chk("R5 slot0 ignored", 1'b1);
      send(20, 2, 1'b1); chk("R5 slot20 ignored", 1'b1);
      repeat (3) @(negedge clk);
      chk("R10 idle hold", 1'b1);
      send(5, 1, 1'b1);  chk("R7 clear via idx1", 1'b0);

      edge_cfg = 32'h1;
      send(5, 0, 1'b1);  chk("R6 pulse high", 1'b1);
      @(negedge clk);    chk("R6 pulse one cycle", 1'b0);
      send(5, 0, 1'b0);  chk("R6 pulse on falling change", 1'b1);
      @(negedge clk);    chk("R6 pulse ends", 1'b0);
      send(5, 0, 1'b0);  chk("R8 edge repeat no pulse", 1'b0);

      edge_cfg = 32'h0;
      pol_cfg  = 32'h1 << 3;
      send(5, 3, 1'b1);  chk("R7 set hold idx3", 1'b1);
      edge_cfg = 32'h1;
      send(5, 0, 1'b1);  chk("R9 pulse over held level", 1'b1);
      @(negedge clk);    chk("R9 held level kept after pulse", 1'b1);

      send(5, 0, 1'b0);
      send(5, 0, 1'b1);  chk("R6 back-to-back pulse", 1'b1);
      @(negedge clk);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule